// File: doc/BRIEF.md
# Keyboard Pin Interrupt Controller

This block watches a small group of external input pins and raises one shared, sticky interrupt flag when an enabled pin shows the activity chosen for it. Every pin has its own enable bit and its own polarity bit. The polarity bit sets the edge direction and also the active level. A global mode bit chooses between edge-only detection and detection of an edge or a held level.

The pins are brought into the bus clock domain by a two-stage synchronizer. A third register keeps the previous synchronized sample, which the edge detector compares against. Software reads and writes three byte-wide registers:

- Control/status (address 0): bit 0 is the read-only flag, bit 1 is the acknowledge bit, bit 2 is the interrupt enable and bit 3 is the mode (1 = edge or level). The acknowledge bit always reads 0.
- Pin enable (address 1).
- Pin polarity (address 2).

Only pin positions 0, 1, 2, 4 and 5 exist. All other bit positions of the enable and polarity registers read as 0.

The flag is a two-state machine, CLEAR and PENDING:

- CLEAR to PENDING (transition "detect") when any enabled pin hits in the current cycle.
- PENDING to CLEAR (transition "acknowledge") on an acknowledge write in a cycle with no hit.
- PENDING stays PENDING (transition "hold") in every other cycle.
- A hit in the same cycle as an acknowledge wins, so the flag stays PENDING.

While the device is stopped, a combinational wake output goes active when any enabled pin sits at its selected level. This path needs no clock.

Top module: `kpi_ctrl`

## Requirements
- R1: After reset all three registers read 0x00, irq_o is 0 and wake_o is 0.
- R2: Bits 3, 6 and 7 of the pin enable (address 1) and pin polarity (address 2) registers always read 0, and a pin at bit 3 never sets the flag.
- R3: A pin whose enable bit is 0 never sets the flag, whatever its activity and whatever the mode.
- R4: With polarity 0 and mode 0, a falling transition on an enabled pin sets the flag (control bit 0) and a rising transition does not.
- R5: With polarity 1 and mode 0, a rising transition on an enabled pin sets the flag and a falling transition does not.
- R6: In mode 0, a pin held steady at its active level does not set the flag again after an acknowledge.
- R7: In mode 1, an acknowledge while an enabled pin is still at its selected level (0 for polarity 0, 1 for polarity 1) leaves the flag set. Once the level is gone, an acknowledge clears the flag.
- R8: Writing 1 to control bit 1 clears the flag. Control bit 1 always reads 0. Writing control bit 0 has no effect on the flag.
- R9: irq_o is 1 exactly when the flag is set and the interrupt enable (control bit 2) is 1.
- R10: A pin transition that changes between two clock edges is reflected in the flag after the third following rising clock edge, and not after the second.
- R11: When stop_i is 1, wake_o is 1 exactly when some enabled pin is at its selected level, with no clock edge needed. When stop_i is 0, wake_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pins_i | input | 8 | External pin levels (asynchronous) |
| stop_i | input | 1 | Device is in stop mode; enables the wake path |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| irq_o | output | 1 | Interrupt request |
| wake_o | output | 1 | Asynchronous wake request while stopped |

## Verification
Directed sequences separate falling from rising edges under each polarity. They also separate edge-only mode, where a held level stays quiet after acknowledge, from edge-or-level mode, where the same held level re-asserts the flag. A separate sequence counts the exact three-edge latency from pin change to flag.

Long random runs vary enables, polarities, mode, pin toggles and acknowledge writes together, and compare the flag and interrupt every cycle against a reference model. These runs expose acknowledge/hit collisions and pins that are disabled or unimplemented.

// File: rtl/kpi_pkg.sv
package kpi_pkg;

    typedef enum logic {
        FLG_CLEAR   = 1'b0,
        FLG_PENDING = 1'b1
    } flag_state_e;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_EN   = 2'd1;
    localparam logic [1:0] ADDR_POL  = 2'd2;

    localparam int BIT_FLAG = 0;
    localparam int BIT_ACK  = 1;
    localparam int BIT_IE   = 2;
    localparam int BIT_MODE = 3;

endpackage

// File: rtl/kpi_sync.sv
module kpi_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pins_i,
    output logic [W-1:0] sync_o,
    output logic [W-1:0] prev_o
);

    logic [W-1:0] stage1;

    for (genvar i = 0; i < W; i++) begin : g_pin
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage1[i] <= 1'b0;
                sync_o[i] <= 1'b0;
                prev_o[i] <= 1'b0;
            end else begin
                stage1[i] <= pins_i[i];
                sync_o[i] <= stage1[i];
                prev_o[i] <= sync_o[i];
            end
        end
    end

endmodule

// File: rtl/kpi_detect.sv
module kpi_detect #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sync_i,
    input  logic [W-1:0] prev_i,
    input  logic [W-1:0] en_i,
    input  logic [W-1:0] pol_i,
    input  logic         level_mode_i,
    output logic         hit_o
);

    logic [W-1:0] edge_v;
    logic [W-1:0] level_v;

    for (genvar i = 0; i < W; i++) begin : g_det
        always_comb begin
            if (pol_i[i]) begin
                edge_v[i] = sync_i[i] & ~prev_i[i];
            end else begin
                edge_v[i] = ~sync_i[i] & prev_i[i];
            end
            level_v[i] = (sync_i[i] == pol_i[i]);
        end
    end

    assign hit_o = |(en_i & (edge_v | ({W{level_mode_i}} & level_v)));

    AST_EDGE_ONLY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!level_mode_i && (sync_i == prev_i)) |-> !hit_o); // R6
    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i == '0) |-> !hit_o); // R3

endmodule

// File: rtl/kpi_regs.sv
module kpi_regs
    import kpi_pkg::*;
#(
    parameter int         W    = 8,
    parameter logic [W-1:0] MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   addr_i,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] rdata_o,
    input  logic         hit_i,
    output logic [W-1:0] en_o,
    output logic [W-1:0] pol_o,
    output logic         level_mode_o,
    output logic         irq_o
);

    flag_state_e flag_q, flag_d;
    logic        ie_q;
    logic        ack;

    assign ack = wr_i && (addr_i == ADDR_CTRL) && wdata_i[BIT_ACK];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_o         <= '0;
            pol_o        <= '0;
            ie_q         <= 1'b0;
            level_mode_o <= 1'b0;
        end else if (wr_i) begin
            unique case (addr_i)
                ADDR_CTRL: begin
                    ie_q         <= wdata_i[BIT_IE];
                    level_mode_o <= wdata_i[BIT_MODE];
                end
                ADDR_EN:  en_o  <= wdata_i & MASK;
                ADDR_POL: pol_o <= wdata_i & MASK;
                default: ;
            endcase
        end
    end

    // flag state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= FLG_CLEAR;
        else        flag_q <= flag_d;
    end

    // flag transitions: detect, acknowledge, hold
    always_comb begin
        flag_d = flag_q;
        unique case (flag_q)
            FLG_CLEAR:   if (hit_i) flag_d = FLG_PENDING;
            FLG_PENDING: if (ack && !hit_i) flag_d = FLG_CLEAR;
            default:     flag_d = FLG_CLEAR;
        endcase
    end

    // outputs
    always_comb begin
        irq_o   = (flag_q == FLG_PENDING) && ie_q;
        rdata_o = '0;
        unique case (addr_i)
            ADDR_CTRL: begin
                rdata_o[BIT_FLAG] = (flag_q == FLG_PENDING);
                rdata_o[BIT_IE]   = ie_q;
                rdata_o[BIT_MODE] = level_mode_o;
            end
            ADDR_EN:  rdata_o = en_o;
            ADDR_POL: rdata_o = pol_o;
            default:  rdata_o = '0;
        endcase
    end

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !hit_i) |=> (flag_q == FLG_CLEAR)); // R8
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ((flag_q == FLG_PENDING) && !ack) |=> (flag_q == FLG_PENDING)); // R8
    AST_SET_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_i) |=> (flag_q == FLG_PENDING)); // R10

endmodule

// File: rtl/kpi_ctrl.sv
module kpi_ctrl #(
    parameter int         W    = 8,
    parameter logic [W-1:0] MASK = 8'h37
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pins_i,
    input  logic         stop_i,
    input  logic [1:0]   bus_addr,
    input  logic         bus_wr,
    input  logic [W-1:0] bus_wdata,
    output logic [W-1:0] bus_rdata,
    output logic         irq_o,
    output logic         wake_o
);

    logic [W-1:0] sync_v, prev_v, en_v, pol_v;
    logic         level_mode, hit;

    kpi_sync #(.W(W)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pins_i (pins_i),
        .sync_o (sync_v),
        .prev_o (prev_v)
    );

    kpi_detect #(.W(W)) u_detect (
        .clk          (clk),
        .rst_n        (rst_n),
        .sync_i       (sync_v),
        .prev_i       (prev_v),
        .en_i         (en_v),
        .pol_i        (pol_v),
        .level_mode_i (level_mode),
        .hit_o        (hit)
    );

    kpi_regs #(.W(W), .MASK(MASK)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .addr_i       (bus_addr),
        .wr_i         (bus_wr),
        .wdata_i      (bus_wdata),
        .rdata_o      (bus_rdata),
        .hit_i        (hit),
        .en_o         (en_v),
        .pol_o        (pol_v),
        .level_mode_o (level_mode),
        .irq_o        (irq_o)
    );

    // clockless wake path straight from the pads
    assign wake_o = stop_i && (|(en_v & ~(pins_i ^ pol_v)));

    AST_WAKE_NEEDS_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        !stop_i |-> !wake_o); // R11

endmodule

// File: tb/kpi_ctrl_tb.sv
module kpi_ctrl_tb;

    localparam logic [7:0] MASK = 8'h37;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pins = 8'hFF;
    logic       stop = 1'b0;
    logic [1:0] addr = 2'd0;
    logic       wr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       irq, wake;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    kpi_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .pins_i(pins), .stop_i(stop),
        .bus_addr(addr), .bus_wr(wr), .bus_wdata(wdata),
        .bus_rdata(rdata), .irq_o(irq), .wake_o(wake)
    );

    // reference model built from the requirements
    logic [7:0] m_en, m_pol, m_s1, m_s2, m_s3;
    logic       m_mode, m_ie, m_flag;

    function automatic logic model_hit(logic [7:0] en, logic [7:0] pol,
                                       logic mode, logic [7:0] cur, logic [7:0] old);
        logic [7:0] e, l;
        e = (pol & cur & ~old) | (~pol & ~cur & old);
        l = ~(cur ^ pol);
        return |(en & (e | ({8{mode}} & l)));
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_en <= 0; m_pol <= 0; m_s1 <= 0; m_s2 <= 0; m_s3 <= 0;
            m_mode <= 0; m_ie <= 0; m_flag <= 0;
        end else begin
            m_s1 <= pins; m_s2 <= m_s1; m_s3 <= m_s2;
            if (model_hit(m_en, m_pol, m_mode, m_s2, m_s3)) m_flag <= 1'b1;
            else if (wr && addr == 2'd0 && wdata[1]) m_flag <= 1'b0;
            if (wr) begin
                case (addr)
                    2'd0: begin m_ie <= wdata[2]; m_mode <= wdata[3]; end
                    2'd1: m_en  <= wdata & MASK;
                    2'd2: m_pol <= wdata & MASK;
                    default: ;
                endcase
            end
        end
    end

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wreg(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0; addr = 2'd0; wdata = 8'h00;
    endtask

    task automatic rreg(logic [1:0] a, output logic [7:0] d);
        addr = a; #0.5; d = rdata; addr = 2'd0;
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic flag_is(string req, logic exp);
        logic [7:0] d;
        rreg(2'd0, d);
        check(req, {7'd0, d[0]}, {7'd0, exp});
    endtask

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rreg(2'd0, d); check("R1 ctrl", d, 8'h00);
        rreg(2'd1, d); check("R1 en", d, 8'h00);
        rreg(2'd2, d); check("R1 pol", d, 8'h00);
        check("R1 irq", {7'd0, irq}, 8'h00);
        check("R1 wake", {7'd0, wake}, 8'h00);

        // R2 unimplemented bits
        wreg(2'd1, 8'hFF); rreg(2'd1, d); check("R2 en mask", d, 8'h37);
        wreg(2'd2, 8'hFF); rreg(2'd2, d); check("R2 pol mask", d, 8'h37);
        wreg(2'd2, 8'h00); wreg(2'd0, 8'h0A); cyc(4); wreg(2'd0, 8'h0A); cyc(2);
        // level mode, all enabled, polarity 0, pins high: toggle bit 3 only
        pins[3] = 1'b0; cyc(5);
        flag_is("R2 bit3 pin", 1'b0);
        pins[3] = 1'b1;

        // R3 disabled pins in level mode
        wreg(2'd1, 8'h00);
        pins = 8'h00; cyc(5);
        flag_is("R3 disabled", 1'b0);
        pins = 8'hFF; cyc(5);
        wreg(2'd0, 8'h02); cyc(1);

        // R4 / R10 falling edge, polarity 0
        wreg(2'd1, 8'h01);
        wreg(2'd2, 8'h00);
        wreg(2'd0, 8'h02);
        cyc(2);
        flag_is("R4 pre", 1'b0);
        pins[0] = 1'b0;
        cyc(2); flag_is("R10 two edges", 1'b0);
        cyc(1); flag_is("R10 three edges", 1'b1);
        wreg(2'd0, 8'h02);
        flag_is("R8 ack clears", 1'b0);
        cyc(5); flag_is("R6 held level quiet", 1'b0);
        pins[0] = 1'b1; cyc(5);
        flag_is("R4 rising ignored", 1'b0);

        // R5 rising edge, polarity 1
        wreg(2'd2, 8'h01); wreg(2'd0, 8'h02);
        pins[0] = 1'b0; cyc(5);
        flag_is("R5 falling ignored", 1'b0);
        pins[0] = 1'b1; cyc(4);
        flag_is("R5 rising sets", 1'b1);

        // R8 flag bit writes, ack reads 0
        wreg(2'd0, 8'h00); flag_is("R8 write 0 to flag", 1'b1);
        rreg(2'd0, d); check("R8 ack reads 0", {7'd0, d[1]}, 8'h00);
        // R9 irq
        wreg(2'd0, 8'h04); check("R9 irq on", {7'd0, irq}, 8'h01);
        wreg(2'd0, 8'h00); check("R9 irq masked", {7'd0, irq}, 8'h00);
        wreg(2'd0, 8'h02); wreg(2'd0, 8'h01);
        flag_is("R8 write 1 to flag", 1'b0);
        wreg(2'd0, 8'h04); check("R9 irq no flag", {7'd0, irq}, 8'h00);

        // R7 level mode
        wreg(2'd2, 8'h00); wreg(2'd0, 8'h0A);
        pins[0] = 1'b0; cyc(4);
        wreg(2'd0, 8'h0A); cyc(1);
        flag_is("R7 ack while level", 1'b1);
        pins[0] = 1'b1; cyc(4);
        wreg(2'd0, 8'h0A); cyc(1);
        flag_is("R7 ack after level", 1'b0);

        // R11 wake path
        wreg(2'd1, 8'h10); wreg(2'd2, 8'h10); wreg(2'd0, 8'h02);
        #1; stop = 1'b1; pins[4] = 1'b1; #0.5;
        check("R11 wake active", {7'd0, wake}, 8'h01);
        pins[4] = 1'b0; #0.5;
        check("R11 wake idle", {7'd0, wake}, 8'h00);
        pins[4] = 1'b1; stop = 1'b0; #0.5;
        check("R11 no stop", {7'd0, wake}, 8'h00);

        // random phase against the model (R3 R4 R5 R7 R9)
        void'($urandom(32'd20240611));
        for (int ep = 0; ep < 12; ep++) begin
            wreg(2'd1, 8'($urandom));
            wreg(2'd2, 8'($urandom));
            wreg(2'd0, {4'd0, 1'($urandom), 1'($urandom), 2'b10});
            for (int c = 0; c < 250; c++) begin
                @(negedge clk);
                wr = 1'b0;
                #0.5;
                check("R3 R4 R5 R7 random flag", {7'd0, rdata[0]}, {7'd0, m_flag});
                check("R9 random irq", {7'd0, irq}, {7'd0, m_flag & m_ie});
                if ($urandom_range(0, 3) == 0) pins = pins ^ (8'd1 << $urandom_range(0, 7));
                if ($urandom_range(0, 9) == 0) begin
                    wr = 1'b1; wdata = {4'd0, m_mode, m_ie, 2'b10};
                end
            end
            @(negedge clk); wr = 1'b0;
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule